// File: doc/BRIEF.md
# Sparse Level Update Link

This block moves occasional level updates from a slow producer to a fast consumer. The consumer needs a valid level on every cycle. The producer marks each cycle that carries a new level with a valid strobe. Those levels go into a small bounded queue. A sender state machine takes entries out of the queue one at a time and passes each one to a receiver state machine over a four-phase request/acknowledge exchange. The receiver loads each delivered level into a hold register. That register drives the output on every cycle, so the consumer always sees the newest delivered level even while the next one is still in transit.

Both sides run on the same clock. The handshake lets the producer and the delivery path run at different rates. A transfer takes several cycles, and the hold register hides that delay. If the producer writes faster than the link can drain, the queue fills up. Any write that arrives while the queue is full is discarded, and a sticky flag records the loss.

Top module: `level_link`

## Requirements
- R1: After reset the output equals the parameter DEFAULT_LEVEL (default 8'h5A), the overflow flag is 0, and the queue is empty. Without writes, the output stays at DEFAULT_LEVEL.
- R2: A cycle with inValid low writes nothing, whatever inLevel holds. The output does not change because of it.
- R3: Delivered levels appear at the output in the order the producer wrote them. None are lost while the queue has room.
- R4: The handshake is four-phase. Request stays high with unchanged data until acknowledge rises. Acknowledge rises only while request is high. Request then falls, and then acknowledge falls.
- R5: Between deliveries the output holds the last delivered level.
- R6: A level written into an empty, idle link becomes visible on the output in the third cycle after the write cycle. In the two cycles before that, the output still shows the previous value.
- R7: One transfer occupies the sender for five cycles. A second level written right behind the first appears five cycles after the first one.
- R8: A write while the queue holds DEPTH entries is dropped, and the overflow flag goes to 1. The flag stays at 1 until reset.
- R9: The queue depth is the parameter DEPTH (default 4). If a burst of writes, one per cycle, starts on an empty idle link, its first DEPTH+1 levels are all delivered in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | High on cycles that carry a new level |
| inLevel | input | DATA_W | Level written when inValid is high |
| outLevel | output | DATA_W | Most recently delivered level, valid on every cycle |
| overflow | output | 1 | Sticky flag: a write was dropped because the queue was full |

## Verification
The assertions check the handshake ordering, the stability of the data, the queue occupancy bound and the stickiness of the overflow flag. They assume nothing about the producer: any pattern on inValid, including a write on every cycle, is legal input. The stimulus drives inputs only at falling edges, so every write is seen whole at one rising edge. The test levels avoid DEFAULT_LEVEL and repeat no value, so each change at the output marks exactly one delivery.

// File: rtl/level_link_pkg.sv
package level_link_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;      // accept inLevel into the queue
    logic pop;       // move queue head into the send register
    logic loadHold;  // copy send register into the hold register
    logic flagOvf;   // write arrived while the queue was full
  } llStrobes_t;

  typedef enum logic [1:0] {
    SEND_IDLE = 2'd0,
    SEND_REQ  = 2'd1,
    SEND_WAIT = 2'd2
  } sendState_t;

  typedef enum logic {
    RECV_IDLE = 1'b0,
    RECV_ACK  = 1'b1
  } recvState_t;

endpackage

// File: rtl/level_link_ctrl.sv
module level_link_ctrl
  import level_link_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  output llStrobes_t strobes,
  output logic       req
);

  sendState_t sendState, sendNext;
  recvState_t recvState, recvNext;
  logic       ack;

  assign req = (sendState == SEND_REQ);
  assign ack = (recvState == RECV_ACK);

  always_comb begin
    strobes.push     = inValid & ~fifoFull;
    strobes.flagOvf  = inValid & fifoFull;
    strobes.pop      = (sendState == SEND_IDLE) & ~fifoEmpty;
    strobes.loadHold = (recvState == RECV_IDLE) & req;
  end

  // Sender: fetch, raise request, wait for ack, drop request, wait ack low
  always_comb begin
    sendNext = sendState;
    unique case (sendState)
      SEND_IDLE: if (!fifoEmpty) sendNext = SEND_REQ;
      SEND_REQ:  if (ack)        sendNext = SEND_WAIT;
      SEND_WAIT: if (!ack)       sendNext = SEND_IDLE;
      default:                   sendNext = SEND_IDLE;
    endcase
  end

  // Receiver: latch on request, hold ack until request drops
  always_comb begin
    recvNext = recvState;
    unique case (recvState)
      RECV_IDLE: if (req)  recvNext = RECV_ACK;
      RECV_ACK:  if (!req) recvNext = RECV_IDLE;
      default:             recvNext = RECV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendState <= SEND_IDLE;
      recvState <= RECV_IDLE;
    end else begin
      sendState <= sendNext;
      recvState <= recvNext;
    end
  end

  // R4: request held until acknowledged
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (req && !ack) |=> req);

  // R4: acknowledge only rises while request is up
  assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> req);

  // R4: acknowledge drops only after request has dropped
  assert_ack_fall_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ack) |-> !req);

endmodule

// File: rtl/level_link_dp.sv
module level_link_dp
  import level_link_pkg::*;
#(
  parameter int              DATA_W        = 8,
  parameter int              DEPTH         = 4,
  parameter logic [DATA_W-1:0] DEFAULT_LEVEL = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  llStrobes_t        strobes,
  input  logic              req,
  input  logic [DATA_W-1:0] inLevel,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [DATA_W-1:0] outLevel,
  output logic              overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] sendData;
  logic [DATA_W-1:0] holdQ;
  logic              overflowQ;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == FULL_CNT);
  assign outLevel  = holdQ;
  assign overflow  = overflowQ;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= inLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      sendData  <= DEFAULT_LEVEL;
      holdQ     <= DEFAULT_LEVEL;
      overflowQ <= 1'b0;
    end else begin
      if (strobes.push) wrPtr <= bump(wrPtr);
      if (strobes.pop) begin
        rdPtr    <= bump(rdPtr);
        sendData <= mem[rdPtr];
      end
      if (strobes.push && !strobes.pop)      count <= count + 1'b1;
      else if (strobes.pop && !strobes.push) count <= count - 1'b1;
      if (strobes.loadHold) holdQ <= sendData;
      if (strobes.flagOvf)  overflowQ <= 1'b1;
    end
  end

  // R8: occupancy never exceeds the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R8: overflow flag is sticky
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ);

  // R4: data presented with a request stays stable while request is held
  assert_send_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (req && $past(req)) |-> $stable(sendData));

  // R5: output only changes on a delivery
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadHold |=> $stable(holdQ));

endmodule

// File: rtl/level_link.sv
module level_link
  import level_link_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter int                DEPTH         = 4,
  parameter logic [DATA_W-1:0] DEFAULT_LEVEL = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLevel,
  output logic [DATA_W-1:0] outLevel,
  output logic              overflow
);

  llStrobes_t strobes;
  logic       req;
  logic       fifoEmpty;
  logic       fifoFull;

  level_link_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .strobes   (strobes),
    .req       (req)
  );

  level_link_dp #(
    .DATA_W        (DATA_W),
    .DEPTH         (DEPTH),
    .DEFAULT_LEVEL (DEFAULT_LEVEL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .req       (req),
    .inLevel   (inLevel),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .outLevel  (outLevel),
    .overflow  (overflow)
  );

endmodule

// File: tb/level_link_test.sv
module level_link_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          DATA_W     = 8;
  localparam int          DEPTH      = 4;
  localparam logic [7:0]  DEF        = 8'h5A;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [DATA_W-1:0] inLevel = '0;
  logic [DATA_W-1:0] outLevel;
  logic             overflow;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 1'b0;

  logic [7:0] seen [64];
  int         seenCount = 0;
  logic [7:0] lastSeen = DEF;

  always #(CLK_PERIOD/2) clk = ~clk;

  level_link #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DEFAULT_LEVEL(DEF)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLevel(inLevel),
    .outLevel(outLevel), .overflow(overflow)
  );

  // Log every change of the output (test values are all distinct)
  always @(negedge clk) begin
    if (rstN && outLevel !== lastSeen) begin
      if (seenCount < 64) seen[seenCount] = outLevel;
      seenCount = seenCount + 1;
      lastSeen  = outLevel;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeOne(input logic [7:0] v);
    inValid = 1'b1;
    inLevel = v;
    @(negedge clk);
    inValid = 1'b0;
    inLevel = 8'hEE;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset;
    check("R1 reset output", outLevel, DEF);
    check("R1 reset overflow", overflow, 0);
    idle(10);
    check("R1 empty queue keeps default", outLevel, DEF);
  endtask

  task automatic testAbsent;
    for (int i = 0; i < 8; i++) begin
      inValid = 1'b0;
      inLevel = 8'h90 + 8'(i);
      @(negedge clk);
    end
    idle(6);
    check("R2 absent cycles ignored", outLevel, DEF);
  endtask

  task automatic testLatency;
    writeOne(8'h11);                 // now at negedge of cycle 1
    check("R6 unchanged cycle 1", outLevel, DEF);
    @(negedge clk);
    check("R6 unchanged cycle 2", outLevel, DEF);
    @(negedge clk);
    check("R6 visible cycle 3", outLevel, 8'h11);
    idle(12);
    check("R5 hold last value", outLevel, 8'h11);
  endtask

  task automatic testBackToBack;
    inValid = 1'b1; inLevel = 8'h21;
    @(negedge clk);
    inLevel = 8'h22;
    @(negedge clk);                  // negedge 2 after first drive
    inValid = 1'b0; inLevel = 8'hEE;
    @(negedge clk);
    check("R6 first visible", outLevel, 8'h21);
    idle(4);                         // negedge 7
    check("R7 second not yet", outLevel, 8'h21);
    @(negedge clk);                  // negedge 8
    check("R7 second after five cycles", outLevel, 8'h22);
    idle(6);
  endtask

  task automatic testLowRate;
    int start;
    start = seenCount;
    for (int i = 0; i < 6; i++) begin
      writeOne(8'h30 + 8'(i));
      idle(2);
      check("R3 low rate delivered", outLevel, 8'h30 + 8'(i));
      idle(5);
    end
    check("R3 low rate count", seenCount - start, 6);
    for (int i = 0; i < 6; i++)
      check("R3 low rate order", seen[start + i], 8'h30 + 8'(i));
    check("R8 no overflow at low rate", overflow, 0);
  endtask

  task automatic testBurst;
    int start;
    int got;
    start = seenCount;
    for (int i = 0; i < 12; i++) begin
      inValid = 1'b1;
      inLevel = 8'h40 + 8'(i);
      @(negedge clk);
    end
    inValid = 1'b0; inLevel = 8'hEE;
    idle(100);
    got = seenCount - start;
    check("R8 overflow set by burst", overflow, 1);
    check("R8 some writes dropped", (got < 12) ? 1 : 0, 1);
    for (int i = 0; i < DEPTH + 1; i++)
      check("R9 first DEPTH+1 delivered", seen[start + i], 8'h40 + 8'(i));
    for (int i = 1; i < got; i++)
      check("R3 burst order increasing",
            (seen[start + i] > seen[start + i - 1]) ? 1 : 0, 1);
    check("R5 output holds last delivered", outLevel, seen[start + got - 1]);
    writeOne(8'h60);
    idle(20);
    check("R8 overflow sticky", overflow, 1);
    check("R3 delivery after overflow", outLevel, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAbsent();
    testLatency();
    testBackToBack();
    testLowRate();
    testBurst();
    // Reset clears the sticky flag and restores the default
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    lastSeen = DEF;
    @(negedge clk);
    check("R1 reset clears overflow", overflow, 0);
    check("R1 reset restores default", outLevel, DEF);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule